// File: doc/BRIEF.md
# Return-Address Stack in Data RAM

This block keeps subroutine and interrupt return state in a small shared data RAM. Each of the eight nesting levels is a pair of bytes in the window from address 8 to address 23. A 3-bit stack pointer lives in the low bits of the processor status word. A call or an interrupt raises `push_req`. The block then stores the 12-bit program counter and the upper status nibble in the pair the pointer selects, and advances the pointer. A return raises `pop_req`. The block steps the pointer back, reads the pair, and hands the saved program counter back. When `pop_psw` is set with the pop, it also hands back the saved status nibble.

The pointer wraps silently in both directions. A ninth nested call overwrites the oldest pair, and a return with nothing stacked reads the top pair. No error is raised in either case. A push takes two RAM write cycles and a pop takes two RAM read cycles. `busy` marks those cycles, and any request that arrives while `busy` is high is dropped. The RAM read port is combinational: `mem_rdata` reflects `mem_addr` in the same cycle.

The controller has five named states:
- `ST_IDLE`: waits for a request.
- `ST_WR_LO`: writes the low byte of the program counter.
- `ST_WR_HI`: writes the packed high byte.
- `ST_RD_LO`: reads the low byte.
- `ST_RD_HI`: reads the high byte.

Transitions:
- `ST_IDLE` goes to `ST_WR_LO` when a push is accepted.
- `ST_IDLE` goes to `ST_RD_LO` when a pop is accepted.
- `ST_WR_LO` always goes to `ST_WR_HI`, and `ST_WR_HI` always returns to `ST_IDLE`, advancing the pointer.
- `ST_RD_LO` always goes to `ST_RD_HI`, and `ST_RD_HI` always returns to `ST_IDLE`, loading the return outputs.

Top module: `ret_stack_ctl`

## Requirements
- R1: After reset, `sp` is 0, `busy` is 0, `mem_we` is 0, and both `ret_pc_load` and `ret_nib_load` are 0.
- R2: Suppose a push is accepted at a clock edge while `sp` is p. In the next cycle, `mem_we` is 1, `mem_addr` is 8+2p and `mem_wdata` is pc[7:0]. In the cycle after that, `mem_we` is 1, `mem_addr` is 9+2p and `mem_wdata` is {nib[3:0], pc[11:8]}. In the following cycle, `mem_we` is 0 and `sp` is p+1.
- R3: A push at `sp` = 7 writes addresses 22 and 23 and leaves `sp` at 0. The next push overwrites the pair at addresses 8 and 9.
- R4: Suppose a pop is accepted at a clock edge while `sp` is p. In the next cycle, `sp` is already p-1 and `mem_addr` is 8+2(p-1). In the cycle after that, `mem_addr` is 9+2(p-1) and `mem_we` stays 0. In the third cycle, `ret_pc_load` is 1 for exactly one cycle, and `ret_pc` is {odd byte[3:0], even byte}. The value returned is the one pushed most recently to that pair.
- R5: A pop at `sp` = 0 leaves `sp` at 7 and reads the pair at addresses 22 and 23.
- R6: A pop with `pop_psw` = 0 keeps `ret_nib_load` at 0 and leaves `ret_nib` unchanged. A pop with `pop_psw` = 1 raises `ret_nib_load` together with `ret_pc_load`, and `ret_nib` becomes odd byte[7:4].
- R7: `psw_view` is {status_hi_in, 1, sp}, so status bit 3 always reads as 1.
- R8: `busy` is 1 in the two RAM cycles that follow an accepted request. A push or pop request seen while `busy` is 1 has no effect on `sp`, on the RAM, or on the return outputs.
- R9: When `push_req` and `pop_req` are both 1 in an idle cycle, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Call or interrupt: save the return state |
| pop_req | input | 1 | Return: restore the program counter |
| pop_psw | input | 1 | Qualifies `pop_req`: also restore the status nibble |
| pc_in | input | 12 | Program counter to save |
| status_hi_in | input | 4 | Current status bits 7..4 |
| mem_addr | output | 8 | Data RAM address |
| mem_we | output | 1 | Data RAM write enable |
| mem_wdata | output | 8 | Data RAM write data |
| mem_rdata | input | 8 | Data RAM read data (combinational) |
| busy | output | 1 | A stack transfer is in progress |
| ret_pc | output | 12 | Restored program counter |
| ret_pc_load | output | 1 | One-cycle strobe: `ret_pc` is fresh |
| ret_nib | output | 4 | Restored status bits 7..4 |
| ret_nib_load | output | 1 | One-cycle strobe: `ret_nib` is fresh |
| sp | output | 3 | Stack pointer |
| psw_view | output | 8 | Status word as seen with the pointer inserted |

## Verification
Directed sequences of nine straight pushes and then a run of pops drive the pointer through both wrap points. They show whether the oldest pair is really overwritten and whether an empty-stack return reads the top pair rather than stalling.

Plain returns are interleaved with status-restoring returns. This separates a nibble load that happens on every pop from one that happens only on the restoring kind.

Requests are injected during `busy`, and push and pop are raised together. These cases expose a controller that queues late requests or favours the wrong request.

A seeded random mix of pushes and pops, with random program counters and status nibbles, is checked against a bench shadow stack. This catches byte-packing and address errors that fixed patterns would mask.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI
    } stk_state_e;
endpackage

// File: rtl/sp_unit.sv
// Wrapping stack pointer; increments and decrements are modulo 2**PTR_W.
module sp_unit #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] sp
);
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= '0;
        else if (inc) sp <= sp + 1'b1;
        else if (dec) sp <= sp - 1'b1;
    end

    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp == PTR_W'($past(sp) + 1'b1));
    p_dec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> sp == PTR_W'($past(sp) - 1'b1));
    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(sp));
endmodule

// File: rtl/pair_map.sv
// Maps a pointer and half-select onto the RAM window and packs the write byte.
module pair_map #(
    parameter int PTR_W  = 3,
    parameter int ADDR_W = 8,
    parameter int BASE   = 8,
    parameter int PC_W   = 12,
    parameter int NIB_W  = 4
) (
    input  logic [PTR_W-1:0]  sp,
    input  logic              hi_half,
    input  logic [PC_W-1:0]   pc,
    input  logic [NIB_W-1:0]  nib,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata
);
    localparam int OFS_W = PTR_W + 1;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs   = {sp, hi_half};
        addr  = ADDR_W'(BASE) + ADDR_W'(ofs);
        wdata = hi_half ? {nib, pc[PC_W-1:8]} : pc[7:0];
    end
endmodule

// File: rtl/ret_stack_ctl.sv
module ret_stack_ctl
    import ret_stack_pkg::*;
#(
    parameter int PTR_W  = 3,
    parameter int ADDR_W = 8,
    parameter int BASE   = 8,
    parameter int PC_W   = 12,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              pop_psw,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [NIB_W-1:0]  status_hi_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic [PC_W-1:0]   ret_pc,
    output logic              ret_pc_load,
    output logic [NIB_W-1:0]  ret_nib,
    output logic              ret_nib_load,
    output logic [PTR_W-1:0]  sp,
    output logic [NIB_W+PTR_W:0] psw_view
);
    localparam int DEPTH = 1 << PTR_W;
    localparam int TOP   = BASE + 2 * DEPTH;

    stk_state_e        state, nxt;
    logic              acc_push, acc_pop, hi_half;
    logic [PC_W-1:0]   cap_pc;
    logic [NIB_W-1:0]  cap_nib;
    logic              restore_q;
    logic [7:0]        lo_q;

    assign acc_push = (state == ST_IDLE) && push_req;
    assign acc_pop  = (state == ST_IDLE) && pop_req && !push_req;

    sp_unit #(.PTR_W(PTR_W)) u_sp (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (state == ST_WR_HI),
        .dec  (acc_pop),
        .sp   (sp)
    );

    pair_map #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BASE(BASE),
               .PC_W(PC_W), .NIB_W(NIB_W)) u_map (
        .sp     (sp),
        .hi_half(hi_half),
        .pc     (cap_pc),
        .nib    (cap_nib),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (push_req)     nxt = ST_WR_LO;
                else if (pop_req) nxt = ST_RD_LO;
            end
            ST_WR_LO: nxt = ST_WR_HI;
            ST_WR_HI: nxt = ST_IDLE;
            ST_RD_LO: nxt = ST_RD_HI;
            ST_RD_HI: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        mem_we  = 1'b0;
        hi_half = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_WR_LO: mem_we = 1'b1;
            ST_WR_HI: begin mem_we = 1'b1; hi_half = 1'b1; end
            ST_RD_LO: ;
            ST_RD_HI: hi_half = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign psw_view = {status_hi_in, 1'b1, sp};

    // Capture and return registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pc       <= '0;
            cap_nib      <= '0;
            restore_q    <= 1'b0;
            lo_q         <= '0;
            ret_pc       <= '0;
            ret_nib      <= '0;
            ret_pc_load  <= 1'b0;
            ret_nib_load <= 1'b0;
        end else begin
            ret_pc_load  <= 1'b0;
            ret_nib_load <= 1'b0;
            if (acc_push) begin
                cap_pc  <= pc_in;
                cap_nib <= status_hi_in;
            end
            if (acc_pop) restore_q <= pop_psw;
            if (state == ST_RD_LO) lo_q <= mem_rdata;
            if (state == ST_RD_HI) begin
                ret_pc      <= {mem_rdata[PC_W-9:0], lo_q};
                ret_pc_load <= 1'b1;
                if (restore_q) begin
                    ret_nib      <= mem_rdata[7:8-NIB_W];
                    ret_nib_load <= 1'b1;
                end
            end
        end
    end

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_addr >= ADDR_W'(BASE)) && (int'(mem_addr) < TOP));
    p_we_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we && mem_addr == $past(mem_addr) + 1'b1);
    p_plain_keeps_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pc_load && !ret_nib_load) |-> $stable(ret_nib));
    p_nib_with_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_nib_load |-> ret_pc_load);
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (push_req || pop_req)) |=> busy);
    p_push_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_req && pop_req) |=> mem_we);
endmodule

// File: tb/sim_ret_stack_ctl.sv
module sim_ret_stack_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pop_req = 1'b0, pop_psw = 1'b0;
    logic [11:0] pc_in = '0;
    logic [3:0]  status_hi_in = '0;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, busy, ret_pc_load, ret_nib_load;
    logic [11:0] ret_pc;
    logic [3:0]  ret_nib;
    logic [2:0]  sp;
    logic [7:0]  psw_view;

    int checks = 0, fails = 0;
    logic [7:0]  ram [256];
    logic [11:0] ref_pc [8];
    logic [3:0]  ref_nib [8];
    logic [2:0]  exp_sp = '0;
    logic [3:0]  exp_nib = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_stack_ctl u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .pop_psw(pop_psw), .pc_in(pc_in), .status_hi_in(status_hi_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .ret_pc(ret_pc),
        .ret_pc_load(ret_pc_load), .ret_nib(ret_nib),
        .ret_nib_load(ret_nib_load), .sp(sp), .psw_view(psw_view)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    function automatic logic [7:0] lo_addr(input logic [2:0] p);
        return 8'd8 + {4'd0, p, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // mode 0: plain, 1: pop request while busy, 2: pop raised together with push
    task automatic do_push(input logic [11:0] pc, input logic [3:0] nib, input int mode);
        logic [7:0] a;
        a = lo_addr(exp_sp);
        pc_in = pc; status_hi_in = nib; push_req = 1'b1;
        pop_req = (mode == 2);
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        chk(busy && mem_we, "R8 busy/we in first write", {busy, mem_we}, 2'b11);
        chk(mem_addr == a && mem_wdata == pc[7:0], "R2 low byte write",
            {mem_addr, mem_wdata}, {a, pc[7:0]});
        if (mode == 1) pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        chk(mem_we && mem_addr == a + 8'd1 && mem_wdata == {nib, pc[11:8]},
            "R2 high byte write", {mem_we, mem_addr, mem_wdata}, {1'b1, a + 8'd1, nib, pc[11:8]});
        ref_pc[exp_sp] = pc; ref_nib[exp_sp] = nib;
        exp_sp = exp_sp + 3'd1;
        @(negedge clk);
        chk(!mem_we && !busy && sp == exp_sp, "R3 pointer after push",
            {mem_we, busy, sp}, {2'b00, exp_sp});
        chk(!ret_pc_load, "R9/R8 no pop performed", ret_pc_load, 0);
        chk(psw_view == {status_hi_in, 1'b1, exp_sp}, "R7 status view",
            psw_view, {status_hi_in, 1'b1, exp_sp});
    endtask

    task automatic do_pop(input bit rest, input bit poke);
        logic [7:0] a;
        exp_sp = exp_sp - 3'd1;
        a = lo_addr(exp_sp);
        pop_req = 1'b1; pop_psw = rest;
        @(negedge clk);
        pop_req = 1'b0; pop_psw = 1'b0;
        chk(sp == exp_sp && busy && !mem_we && mem_addr == a, "R4/R5 even read",
            {sp, busy, mem_we, mem_addr}, {exp_sp, 2'b10, a});
        if (poke) push_req = 1'b1;
        @(negedge clk);
        push_req = 1'b0;
        chk(!mem_we && mem_addr == a + 8'd1, "R4 odd read",
            {mem_we, mem_addr}, {1'b0, a + 8'd1});
        if (rest) exp_nib = ref_nib[exp_sp];
        @(negedge clk);
        chk(ret_pc_load && ret_pc == ref_pc[exp_sp], "R4 restored pc",
            {ret_pc_load, ret_pc}, {1'b1, ref_pc[exp_sp]});
        chk(ret_nib_load == rest && ret_nib == exp_nib, "R6 status nibble",
            {ret_nib_load, ret_nib}, {rest, exp_nib});
        chk(!busy && !mem_we && sp == exp_sp, "R8 idle after pop",
            {busy, mem_we, sp}, {2'b00, exp_sp});
        @(negedge clk);
        chk(!ret_pc_load && !ret_nib_load && !busy, "R4 one-cycle strobe / R8 drop",
            {ret_pc_load, ret_nib_load, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        for (int i = 0; i < 256; i++) ram[i] = '0;
        for (int i = 0; i < 8; i++) begin ref_pc[i] = '0; ref_nib[i] = '0; end
        seed_v = $urandom(32'h5eed_0017);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == 0 && !busy && !mem_we && !ret_pc_load && !ret_nib_load,
            "R1 reset state", {sp, busy, mem_we, ret_pc_load, ret_nib_load}, 0);
        chk(psw_view[3] == 1'b1, "R7 bit 3 reads one", psw_view, 8'h08);
        // Nine pushes: pointer wraps 7 -> 0 and the ninth overwrites pair 8/9 (R3)
        for (int i = 0; i < 9; i++) do_push(12'h100 + 12'(i * 17), 4'(i + 3), 0);
        chk(ram[8] == 8'h88 && ram[9] == 8'hB1, "R3 oldest pair overwritten",
            {ram[9], ram[8]}, 16'hB188);
        do_pop(1'b0, 1'b0);          // plain pop from 1 -> 0
        do_pop(1'b1, 1'b0);          // restoring pop from 0 wraps to 7 (R5)
        do_pop(1'b0, 1'b1);          // push request during busy is dropped (R8)
        do_push(12'hABC, 4'h5, 1);   // pop request during busy is dropped (R8)
        do_push(12'h3E7, 4'hA, 2);   // push and pop together: push wins (R9)
        do_pop(1'b1, 1'b0);
        do_pop(1'b1, 1'b0);
        for (int n = 0; n < 80; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) do_push(r[19:8], r[23:20], 0);
            else      do_pop(r[1], 1'b0);
        end
        finish_run();
    end
endmodule